// File: doc/BRIEF.md
# Per-Channel DAC Power-Down Controller

This block sits behind the serial frame decoder of a four-channel DAC and acts on the power-down command. A 32-bit frame arrives with a one-cycle valid strobe. When the frame carries the power-down opcode, the block takes a two-bit termination mode and a four-bit channel mask from the frame. Only the masked channels take the new mode. Each channel's output termination select is driven from its own mode register. The terminations are: driven normally, 1 k to ground, 100 k to ground, or open.

A channel that goes from any powered-down mode back to normal starts a wake-up timer. The timer counts the analog settling time (2.5 µs by default) in clock cycles of a parameterized clock. The channel's ready flag stays low until the timer has expired. At the moment of wake-up the block samples the active-low load pin. If the pin is low, the block issues a one-cycle pulse telling the register bank to copy the input register into the DAC register. If the pin is high, it issues no pulse, and the DAC register keeps the value it held before power-down. A software-reset frame returns every channel to normal. The hardware reset does the same.

Top module: `dac_pd_ctrl`

## Requirements
- R1: After reset, every channel's termination select is 00 (normal), every ready flag is 1 and no load pulse is asserted.
- R2: A valid frame whose bits 27..24 equal 0100 is a power-down command. Its bits 9..8 give the mode: 00 normal, 01 1 k to ground, 10 100 k to ground, 11 open. Every other frame bit is ignored. The new termination is visible on `term_sel` one clock after the frame.
- R3: Frame bits 3..0 select the channels, bit 0 being channel A (term_sel[1:0], ready[0]) up to bit 3 for channel D (term_sel[7:6], ready[3]). Only channels whose bit is 1 take the mode.
- R4: A channel whose mask bit is 0 keeps both its mode and its wake-up timer progress unchanged.
- R5: A valid frame with any opcode other than 0100 or 0111 changes no output.
- R6: A channel placed into any non-normal mode has ready low from the next clock onward, and no load pulse is issued for it.
- R7: A channel that goes from a powered-down mode to normal drops ready and raises it again exactly WAKE_CYC clocks after the command clock. WAKE_CYC is 125 at the default 50 MHz clock and 2500 ns settling time.
- R8: At such a wake-up the channel's `wake_load` bit pulses for exactly one clock if `ldac_n` was 0 in the command cycle. If `ldac_n` was 1, there is no pulse.
- R9: Commanding normal mode on a channel that is already normal neither restarts its timer nor pulses `wake_load`.
- R10: A valid frame with bits 27..24 equal 0111 returns all channels to normal with ready high and clears all timers on the next clock.
- R11: Moving a channel from one powered-down mode to another changes only its termination. Ready stays low and there is no load pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One-cycle strobe marking a complete frame |
| frame_data | input | 32 | Decoded frame word |
| ldac_n | input | 1 | Active-low load pin level |
| term_sel | output | 8 | Two-bit termination select per channel, channel A in the low bits |
| ready | output | 4 | Per-channel output-valid flag |
| wake_load | output | 4 | One-cycle request to copy the input register into the DAC register |

## Verification
The bench fills every frame bit outside the three decoded fields with ones. A decoder that read the mode or mask from the wrong bits would therefore produce wrong terminations. It counts the wake-up interval to the exact clock, so an off-by-one timer raises ready one cycle early or late. It also restarts a second channel mid-count, which exposes a design that resets all timers on any frame. Further cases include a power-up of a channel that is already normal, a mode change between two powered-down modes, and a wake-up with the load pin high and again with it low. A design that restarted timers spuriously would fail these cases. So would one that pulsed the load request on entry to power-down or ignored the load pin.

// File: rtl/dacpd_pkg.sv
package dacpd_pkg;

    localparam int NCH       = 4;
    localparam int FRAME_W   = 32;
    localparam int OP_LSB    = 24;
    localparam int OP_W      = 4;
    localparam int MODE_LSB  = 8;
    localparam int MASK_LSB  = 0;

    localparam logic [OP_W-1:0] OP_POWER = 4'b0100;
    localparam logic [OP_W-1:0] OP_RESET = 4'b0111;

    typedef enum logic [1:0] {
        TERM_ACTIVE = 2'b00,
        TERM_1K     = 2'b01,
        TERM_100K   = 2'b10,
        TERM_OPEN   = 2'b11
    } term_e;

    typedef struct packed {
        logic            pd_en;
        logic            rst_en;
        term_e           mode;
        logic [NCH-1:0]  mask;
    } pd_req_t;

    function automatic pd_req_t unpack_frame(input logic v, input logic [FRAME_W-1:0] f);
        pd_req_t r;
        logic [OP_W-1:0] op;
        op       = f[OP_LSB +: OP_W];
        r.pd_en  = v && (op == OP_POWER);
        r.rst_en = v && (op == OP_RESET);
        r.mode   = term_e'(f[MODE_LSB +: 2]);
        r.mask   = f[MASK_LSB +: NCH];
        return r;
    endfunction

    function automatic int wake_cycles(input int clk_hz, input int settle_ns);
        int c;
        c = ((clk_hz / 1000) * settle_ns) / 1000000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/dacpd_decode.sv
module dacpd_decode
    import dacpd_pkg::*;
(
    input  logic               frame_valid,
    input  logic [FRAME_W-1:0] frame_data,
    output pd_req_t            req
);
    always_comb req = unpack_frame(frame_valid, frame_data);

    always_comb begin
        assert_op_exclusive_R5: assert (!(req.pd_en && req.rst_en));
    end
endmodule

// File: rtl/dacpd_channel.sv
module dacpd_channel
    import dacpd_pkg::*;
#(
    parameter int WAKE_CYC = 125,
    localparam int CNT_W   = $clog2(WAKE_CYC + 1)
)(
    input  logic  clk,
    input  logic  rst,
    input  logic  pd_en,
    input  logic  rst_en,
    input  logic  sel,
    input  term_e mode_in,
    input  logic  ldac_n,
    output term_e term,
    output logic  ready,
    output logic  wake_load
);
    term_e             mode_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              hit;
    logic              waking;

    assign hit    = pd_en && sel;
    assign waking = hit && (mode_in == TERM_ACTIVE) && (mode_q != TERM_ACTIVE);

    always_ff @(posedge clk) begin
        if (rst || rst_en) begin
            mode_q    <= TERM_ACTIVE;
            cnt_q     <= '0;
            wake_load <= 1'b0;
        end else begin
            wake_load <= 1'b0;
            if (hit) begin
                mode_q <= mode_in;
                if (waking) begin
                    cnt_q     <= CNT_W'(WAKE_CYC);
                    wake_load <= !ldac_n;
                end else if (mode_in != TERM_ACTIVE) begin
                    cnt_q <= '0;
                end else if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign term  = mode_q;
    assign ready = (mode_q == TERM_ACTIVE) && (cnt_q == '0);

    assert_hold_unsel_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst_en && !hit) |=> $stable(mode_q));
    assert_pd_not_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (!rst_en && hit && mode_in != TERM_ACTIVE) |=> (!ready && !wake_load));
    assert_wake_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (!rst_en && waking) |=> !ready);
    assert_load_pin_R8: assert property (@(posedge clk) disable iff (rst)
        wake_load |-> $past(!ldac_n));
    assert_swreset_R10: assert property (@(posedge clk) disable iff (rst)
        rst_en |=> (ready && term == TERM_ACTIVE));
endmodule

// File: rtl/dac_pd_ctrl.sv
module dac_pd_ctrl
    import dacpd_pkg::*;
#(
    parameter int CLK_HZ  = 50000000,
    parameter int WAKE_NS = 2500,
    localparam int WAKE_CYC = wake_cycles(CLK_HZ, WAKE_NS)
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_valid,
    input  logic [FRAME_W-1:0] frame_data,
    input  logic               ldac_n,
    output logic [2*NCH-1:0]   term_sel,
    output logic [NCH-1:0]     ready,
    output logic [NCH-1:0]     wake_load
);
    pd_req_t req;

    dacpd_decode u_dec (
        .frame_valid (frame_valid),
        .frame_data  (frame_data),
        .req         (req)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        term_e t;
        dacpd_channel #(.WAKE_CYC(WAKE_CYC)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .pd_en     (req.pd_en),
            .rst_en    (req.rst_en),
            .sel       (req.mask[i]),
            .mode_in   (req.mode),
            .ldac_n    (ldac_n),
            .term      (t),
            .ready     (ready[i]),
            .wake_load (wake_load[i])
        );
        assign term_sel[2*i +: 2] = t;
    end
endmodule

// File: tb/sim_dac_pd_ctrl.sv
module sim_dac_pd_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_valid = 1'b0;
    logic [31:0] frame_data = '0;
    logic        ldac_n = 1'b1;
    logic [7:0]  term_sel;
    logic [3:0]  ready;
    logic [3:0]  wake_load;

    int checks = 0;
    int errors = 0;
    localparam int WAKE = 125; // R7: 2.5 us at 50 MHz

    always #10 clk = ~clk;

    dac_pd_ctrl u0 (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_data(frame_data),
        .ldac_n(ldac_n), .term_sel(term_sel), .ready(ready), .wake_load(wake_load)
    );

    // {opcode, mode, mask, expected term_sel, expected ready}
    localparam int NV = 8;
    localparam logic [21:0] VEC [NV] = '{
        {4'b0100, 2'b01, 4'b0001, 8'h01, 4'hE},  // R2 R3 R6
        {4'b0100, 2'b10, 4'b0110, 8'h29, 4'h8},  // R3
        {4'b0011, 2'b11, 4'b1111, 8'h29, 4'h8},  // R5
        {4'b0100, 2'b11, 4'b1000, 8'hE9, 4'h0},  // R2
        {4'b0100, 2'b11, 4'b0001, 8'hEB, 4'h0},  // R11
        {4'b0100, 2'b00, 4'b0100, 8'hCB, 4'h0},  // R7
        {4'b0111, 2'b00, 4'b0000, 8'h00, 4'hF},  // R10
        {4'b0100, 2'b00, 4'b1111, 8'h00, 4'hF}   // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] op, input logic [1:0] mode, input logic [3:0] mask);
        logic [31:0] f;
        @(negedge clk);
        f = 32'hFFFF_FFFF;
        f[27:24] = op;
        f[9:8]   = mode;
        f[3:0]   = mask;
        frame_data  = f;
        frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
        frame_data  = 32'h0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 term", term_sel, 8'h00);
        check("R1 ready", ready, 4'hF);
        check("R1 load", wake_load, 4'h0);

        for (int k = 0; k < NV; k++) begin
            send(VEC[k][21:18], VEC[k][17:16], VEC[k][15:12]);
            check($sformatf("vec%0d term", k), term_sel, VEC[k][11:4]);
            check($sformatf("vec%0d ready", k), ready, VEC[k][3:0]);
            check($sformatf("vec%0d load R8", k), wake_load, 4'h0);
        end

        // R7 / R8: exact wake interval, load pin low gives a pulse
        send(4'b0100, 2'b10, 4'b0001);
        ldac_n = 1'b0;
        send(4'b0100, 2'b00, 4'b0001);
        ldac_n = 1'b1;
        check("R8 pulse low pin", wake_load, 4'h1);
        check("R7 ready low", ready, 4'hE);
        @(negedge clk);
        check("R8 pulse one cycle", wake_load, 4'h0);
        repeat (WAKE - 2) @(negedge clk);
        check("R7 ready still low", ready, 4'hE);
        @(negedge clk);
        check("R7 ready rises", ready, 4'hF);

        // R4: selecting another channel leaves A's countdown intact; R8 pin high
        send(4'b0100, 2'b01, 4'b0011);
        send(4'b0100, 2'b00, 4'b0001);
        check("R8 no pulse high pin", wake_load, 4'h0);
        send(4'b0100, 2'b10, 4'b0010);
        check("R4 other term", term_sel, 8'h08);
        repeat (WAKE - 3) @(negedge clk);
        check("R4 A still counting", ready, 4'hC);
        @(negedge clk);
        check("R4 A ready on time", ready, 4'hD);

        // R10 during a countdown
        send(4'b0100, 2'b00, 4'b0010);
        check("R7 B waking", ready, 4'hD);
        send(4'b0111, 2'b11, 4'b0000);
        check("R10 ready", ready, 4'hF);
        check("R10 term", term_sel, 8'h00);

        // R1: hardware reset mid-state
        send(4'b0100, 2'b11, 4'b1111);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 after reset term", term_sel, 8'h00);
        check("R1 after reset ready", ready, 4'hF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule